// File: doc/BRIEF.md
# Priority-Masked Pending Interrupt Selector

This block picks, for each of several processor targets, the most urgent interrupt that is both enabled and pending for that target, and decides whether that target should be interrupted. Priorities are 8-bit values, and a smaller number means a more urgent interrupt. The chosen interrupt passes two gates. The first is a per-target priority mask: a winner that fails the mask leaves the reported pending ID at the spurious value 1023. The second is the priority of the interrupt the target is already running. A winner can pass the mask and still fail this gate, so the pending ID may be valid while the request line stays low.

The selection is a sequential scan driven by a small state machine. In `ST_LOAD` the block takes a snapshot of every input and resets each target's running best to the idle priority 0x100 with ID 1023. It then moves to `ST_SCAN`, which walks the snapshot one chunk of `LANES` interrupts per cycle for `NUM_IRQ/LANES` cycles, lowest IDs first. After the last chunk it goes to `ST_PUBLISH`, where the qualified results are registered onto the outputs, and then returns to `ST_LOAD`. The transitions are fixed: LOAD to SCAN, SCAN to SCAN until the last chunk, SCAN to PUBLISH on the last chunk, and PUBLISH to LOAD. One pass therefore takes `NUM_IRQ/LANES + 2` cycles.

Priorities are shared by all targets. Enable and pending are given per target and per interrupt, packed as bit `t*NUM_IRQ + id`. `NUM_IRQ` must be a multiple of 32 and no larger than 992. `LANES` must divide `NUM_IRQ`.

Top module: `prio_pend_sel`

## Requirements
- R1: Among the interrupts that take part, the winner for a target is the one with the numerically smallest 8-bit priority. The priority of interrupt `id` is `prio_i[id*8 +: 8]`.
- R2: When several interrupts share the smallest priority, the lowest interrupt ID wins.
- R3: An interrupt takes part for target t only when both `enable_i` and `pending_i` are set at bit `t*NUM_IRQ + id`. Either bit alone has no effect on that target's outputs.
- R4: The pending ID of target t (`pend_id_o[t*10 +: 10]`) is the winner's ID only when the winner's priority is strictly below `prio_mask_i[t*8 +: 8]`. Otherwise it is 1023. A mask of 0 blocks every interrupt, and a priority equal to the mask is blocked.
- R5: `irq_o[t]` is high only when the pending ID is valid and the winner's priority is strictly below the 9-bit running priority `run_prio_i[t*9 +: 9]`. A running priority of 0x100 means idle. A winner whose priority equals the running priority leaves the ID valid and the request low.
- R6: When `dist_en_i` is low, every target reports ID 1023 with its request low. When `tgt_en_i[t]` is low, target t alone does.
- R7: A target with no enabled-and-pending interrupt reports ID 1023 with its request low.
- R8: Inputs are sampled at the first rising edge after reset is released and then every `NUM_IRQ/LANES + 2` edges. The outputs for a sample change at edge `NUM_IRQ/LANES + 1` after that sample and hold at every other edge. Changes between samples have no effect on the result being computed.
- R9: While reset is asserted, every pending ID is 1023 and every request is low.
- R10: Each target is selected and qualified independently of the other targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_en_i | input | 1 | Global enable for all targets |
| tgt_en_i | input | NUM_TGT | Per-target interface enable |
| enable_i | input | NUM_TGT*NUM_IRQ | Per-target interrupt enables, bit t*NUM_IRQ+id |
| pending_i | input | NUM_TGT*NUM_IRQ | Per-target pending flags, bit t*NUM_IRQ+id |
| prio_i | input | NUM_IRQ*8 | Shared 8-bit priority per interrupt |
| prio_mask_i | input | NUM_TGT*8 | Per-target priority mask |
| run_prio_i | input | NUM_TGT*9 | Per-target running priority, 0x100 when idle |
| pend_id_o | output | NUM_TGT*10 | Per-target selected pending ID, 1023 when none |
| irq_o | output | NUM_TGT | Per-target interrupt request |

## Verification
The hardest situations to reach from the ports are the strict-inequality edges. These are a winner whose priority equals the mask, a winner whose priority equals the running priority (valid ID, no request), and equal priorities spread across chunk boundaries, where only a strict compare keeps the lower ID. Directed phases set up each of these exactly and hold them for more than two scan periods. Random phases then change the inputs at arbitrary points inside a scan, with coarse priority values so that ties happen often. This checks that the snapshot isolates each pass from mid-scan changes.

// File: rtl/sel_pkg.sv
package sel_pkg;
    localparam int ID_W = 10;
    localparam int PRIO_W = 8;
    localparam int RUN_W = PRIO_W + 1;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
    localparam logic [RUN_W-1:0] IDLE_PRIO = 9'h100;

    typedef enum logic [1:0] {
        ST_LOAD,
        ST_SCAN,
        ST_PUBLISH
    } scan_state_e;

    typedef struct packed {
        logic [RUN_W-1:0] prio;
        logic [ID_W-1:0]  id;
    } cand_t;
endpackage

// File: rtl/sel_scan_ctrl.sv
module sel_scan_ctrl
    import sel_pkg::*;
#(
    parameter int NUM_CHUNK = 4,
    localparam int CW = (NUM_CHUNK > 1) ? $clog2(NUM_CHUNK) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] chunk_o,
    output logic          load_o,
    output logic          scan_o,
    output logic          pub_o
);
    localparam logic [CW-1:0] LAST_CHUNK = CW'(NUM_CHUNK - 1);

    scan_state_e state_q, state_d;
    logic [CW-1:0] chunk_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            chunk_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SCAN && chunk_q != LAST_CHUNK)
                chunk_q <= chunk_q + 1'b1;
            else
                chunk_q <= '0;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:    state_d = ST_SCAN;
            ST_SCAN:    state_d = (chunk_q == LAST_CHUNK) ? ST_PUBLISH : ST_SCAN;
            ST_PUBLISH: state_d = ST_LOAD;
            default:    state_d = ST_LOAD;
        endcase
    end

    // outputs
    always_comb begin
        load_o = 1'b0;
        scan_o = 1'b0;
        pub_o  = 1'b0;
        unique case (state_q)
            ST_LOAD:    load_o = 1'b1;
            ST_SCAN:    scan_o = 1'b1;
            ST_PUBLISH: pub_o  = 1'b1;
            default:    load_o = 1'b0;
        endcase
    end

    assign chunk_o = chunk_q;

    assert_chunk_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_q <= LAST_CHUNK);
    assert_publish_then_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pub_o |=> load_o);
    assert_load_then_scan_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (scan_o && chunk_o == '0));
endmodule

// File: rtl/sel_chunk_min.sv
module sel_chunk_min
    import sel_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0]        elig_i,
    input  logic [LANES*PRIO_W-1:0] prio_i,
    input  logic [ID_W-1:0]         base_id_i,
    output cand_t                   cand_o
);
    // ascending walk with strict compare: lowest lane wins ties
    always_comb begin
        cand_t best;
        best.prio = IDLE_PRIO;
        best.id   = SPURIOUS_ID;
        for (int i = 0; i < LANES; i++) begin
            if (elig_i[i] && ({1'b0, prio_i[i*PRIO_W +: PRIO_W]} < best.prio)) begin
                best.prio = {1'b0, prio_i[i*PRIO_W +: PRIO_W]};
                best.id   = base_id_i + ID_W'(i);
            end
        end
        cand_o = best;
    end
endmodule

// File: rtl/sel_target_slot.sv
module sel_target_slot
    import sel_pkg::*;
#(
    parameter int NUM_IRQ = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              scan_i,
    input  logic              pub_i,
    input  cand_t             cand_i,
    input  logic              gate_i,
    input  logic [PRIO_W-1:0] mask_i,
    input  logic [RUN_W-1:0]  run_i,
    output logic [ID_W-1:0]   id_o,
    output logic              irq_o
);
    logic [RUN_W-1:0] best_prio_q;
    logic [ID_W-1:0]  best_id_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_prio_q <= IDLE_PRIO;
            best_id_q   <= SPURIOUS_ID;
        end else if (load_i) begin
            best_prio_q <= IDLE_PRIO;
            best_id_q   <= SPURIOUS_ID;
        end else if (scan_i && (cand_i.prio < best_prio_q)) begin
            best_prio_q <= cand_i.prio;
            best_id_q   <= cand_i.id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_o  <= SPURIOUS_ID;
            irq_o <= 1'b0;
        end else if (pub_i) begin
            if (gate_i && (best_prio_q < {1'b0, mask_i})) begin
                id_o  <= best_id_q;
                irq_o <= (best_prio_q < run_i);
            end else begin
                id_o  <= SPURIOUS_ID;
                irq_o <= 1'b0;
            end
        end
    end

    assert_best_never_rises_R2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_i |=> (best_prio_q <= $past(best_prio_q)));
    assert_gate_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pub_i && !gate_i) |=> (id_o == SPURIOUS_ID && !irq_o));
    assert_req_needs_id_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (id_o != SPURIOUS_ID));
    assert_id_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (id_o == SPURIOUS_ID) || (int'(id_o) < NUM_IRQ));
endmodule

// File: rtl/prio_pend_sel.sv
module prio_pend_sel
    import sel_pkg::*;
#(
    parameter int NUM_IRQ = 128,
    parameter int NUM_TGT = 4,
    parameter int LANES   = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        dist_en_i,
    input  logic [NUM_TGT-1:0]          tgt_en_i,
    input  logic [NUM_TGT*NUM_IRQ-1:0]  enable_i,
    input  logic [NUM_TGT*NUM_IRQ-1:0]  pending_i,
    input  logic [NUM_IRQ*PRIO_W-1:0]   prio_i,
    input  logic [NUM_TGT*PRIO_W-1:0]   prio_mask_i,
    input  logic [NUM_TGT*RUN_W-1:0]    run_prio_i,
    output logic [NUM_TGT*ID_W-1:0]     pend_id_o,
    output logic [NUM_TGT-1:0]          irq_o
);
    localparam int NUM_CHUNK = NUM_IRQ / LANES;
    localparam int CW = (NUM_CHUNK > 1) ? $clog2(NUM_CHUNK) : 1;
    localparam logic [ID_W-1:0] LANES_ID = ID_W'(LANES);

    logic [CW-1:0] chunk_w;
    logic load_w, scan_w, pub_w;

    // snapshot of all inputs, taken in ST_LOAD
    logic [NUM_TGT*NUM_IRQ-1:0] elig_q;
    logic [NUM_IRQ*PRIO_W-1:0]  prio_q;
    logic [NUM_TGT-1:0]         gate_q;
    logic [NUM_TGT*PRIO_W-1:0]  mask_q;
    logic [NUM_TGT*RUN_W-1:0]   run_q;

    sel_scan_ctrl #(.NUM_CHUNK(NUM_CHUNK)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .chunk_o (chunk_w),
        .load_o  (load_w),
        .scan_o  (scan_w),
        .pub_o   (pub_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elig_q <= '0;
            prio_q <= '0;
            gate_q <= '0;
            mask_q <= '0;
            run_q  <= '0;
        end else if (load_w) begin
            elig_q <= enable_i & pending_i;
            prio_q <= prio_i;
            gate_q <= {NUM_TGT{dist_en_i}} & tgt_en_i;
            mask_q <= prio_mask_i;
            run_q  <= run_prio_i;
        end
    end

    logic [LANES*PRIO_W-1:0] prio_chunks [NUM_CHUNK];
    logic [LANES*PRIO_W-1:0] prio_sel;
    logic [ID_W-1:0]         base_id;

    for (genvar c = 0; c < NUM_CHUNK; c++) begin : g_prio_chunk
        assign prio_chunks[c] = prio_q[c*LANES*PRIO_W +: LANES*PRIO_W];
    end

    assign prio_sel = prio_chunks[chunk_w];
    assign base_id  = ID_W'(chunk_w) * LANES_ID;

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        logic [LANES-1:0] elig_chunks [NUM_CHUNK];
        cand_t            cand;

        for (genvar c = 0; c < NUM_CHUNK; c++) begin : g_elig_chunk
            assign elig_chunks[c] = elig_q[t*NUM_IRQ + c*LANES +: LANES];
        end

        sel_chunk_min #(.LANES(LANES)) u_min (
            .elig_i    (elig_chunks[chunk_w]),
            .prio_i    (prio_sel),
            .base_id_i (base_id),
            .cand_o    (cand)
        );

        sel_target_slot #(.NUM_IRQ(NUM_IRQ)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load_w),
            .scan_i (scan_w),
            .pub_i  (pub_w),
            .cand_i (cand),
            .gate_i (gate_q[t]),
            .mask_i (mask_q[t*PRIO_W +: PRIO_W]),
            .run_i  (run_q[t*RUN_W +: RUN_W]),
            .id_o   (pend_id_o[t*ID_W +: ID_W]),
            .irq_o  (irq_o[t])
        );
    end

    assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pub_w |=> ($stable(pend_id_o) && $stable(irq_o)));
endmodule

// File: tb/sim_prio_pend_sel.sv
`timescale 1ns/1ps
module sim_prio_pend_sel;
    localparam int NI  = 128;
    localparam int NT  = 4;
    localparam int LN  = 32;
    localparam int NC  = NI / LN;
    localparam int PER = NC + 2;
    localparam int HOLD = 2 * PER + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dist_en;
    logic [NT-1:0] tgt_en;
    logic [NT*NI-1:0] en, pend;
    logic [NI*8-1:0] prio;
    logic [NT*8-1:0] mask;
    logic [NT*9-1:0] runp;
    logic [NT*10-1:0] pid;
    logic [NT-1:0] irq;

    always #4 clk = ~clk;

    prio_pend_sel #(.NUM_IRQ(NI), .NUM_TGT(NT), .LANES(LN)) u0 (
        .clk(clk), .rst_n(rst_n), .dist_en_i(dist_en), .tgt_en_i(tgt_en),
        .enable_i(en), .pending_i(pend), .prio_i(prio), .prio_mask_i(mask),
        .run_prio_i(runp), .pend_id_o(pid), .irq_o(irq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string req_tag = "R9";
    int snap_id [NT];
    int snap_irq[NT];
    int exp_id  [NT];
    int exp_irq [NT];
    int ph = 0;
    bit done = 1'b0;

    // behavioural model of one selection over the current inputs
    task automatic model_eval();
        for (int t = 0; t < NT; t++) begin
            int best = 256;
            int bid = 1023;
            snap_id[t] = 1023;
            snap_irq[t] = 0;
            if (dist_en && tgt_en[t]) begin
                for (int i = 0; i < NI; i++)
                    if (en[t*NI+i] && pend[t*NI+i] && int'(prio[i*8 +: 8]) < best) begin
                        best = int'(prio[i*8 +: 8]);
                        bid = i;
                    end
                if (best < int'(mask[t*8 +: 8])) begin
                    snap_id[t] = bid;
                    snap_irq[t] = (best < int'(runp[t*9 +: 9])) ? 1 : 0;
                end
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0;
            for (int t = 0; t < NT; t++) begin
                exp_id[t] = 1023;
                exp_irq[t] = 0;
            end
        end else begin
            if (ph == 0) model_eval();
            if (ph == NC + 1)
                for (int t = 0; t < NT; t++) begin
                    exp_id[t] = snap_id[t];
                    exp_irq[t] = snap_irq[t];
                end
            ph = (ph == PER - 1) ? 0 : ph + 1;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            for (int t = 0; t < NT; t++) begin
                n_cmp++;
                if (int'(pid[t*10 +: 10]) != exp_id[t] || int'(irq[t]) != exp_irq[t]) begin
                    n_bad++;
                    $display("FAIL %s tgt %0d: id %0d irq %0d, expected id %0d irq %0d",
                             req_tag, t, pid[t*10 +: 10], irq[t], exp_id[t], exp_irq[t]);
                end
            end
        end
    end

    task automatic clear_all();
        dist_en = 1'b1;
        tgt_en = '1;
        en = '0;
        pend = '0;
        prio = '1;
        mask = '1;
        runp = {NT{9'h100}};
    endtask

    task automatic arm(input int t, input int i, input int p);
        en[t*NI+i] = 1'b1;
        pend[t*NI+i] = 1'b1;
        prio[i*8 +: 8] = 8'(p);
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        clear_all();
        dist_en = 1'b0;
        hold(3);                 // R9: outputs checked during reset
        rst_n = 1'b1;
        hold(HOLD);

        req_tag = "R7"; clear_all(); hold(HOLD);

        req_tag = "R1"; clear_all();
        arm(0, 5, 8'h40); arm(0, 70, 8'h10); arm(0, 100, 8'h80);
        hold(HOLD);              // expect 70, request high

        req_tag = "R2"; clear_all();
        arm(0, 40, 8'h20); arm(0, 90, 8'h20); arm(0, 127, 8'h20);
        arm(1, 3, 8'h20); arm(1, 2, 8'h20);
        hold(HOLD);              // expect 40 on t0, 2 on t1

        req_tag = "R3"; clear_all();
        en[0*NI+10] = 1'b0; pend[0*NI+10] = 1'b1; prio[10*8 +: 8] = 8'h00;
        en[0*NI+11] = 1'b1; pend[0*NI+11] = 1'b0; prio[11*8 +: 8] = 8'h00;
        arm(0, 12, 8'h90);
        hold(HOLD);              // expect 12 on t0

        req_tag = "R10";
        en[1*NI+10] = 1'b1; pend[1*NI+10] = 1'b1;
        hold(HOLD);              // t1 alone sees 10

        req_tag = "R4"; clear_all();
        arm(2, 33, 8'h50);
        mask[2*8 +: 8] = 8'h50; hold(HOLD);   // equal: blocked
        mask[2*8 +: 8] = 8'h51; hold(HOLD);   // passes
        mask[2*8 +: 8] = 8'h00; hold(HOLD);   // blocks all

        req_tag = "R5"; clear_all();
        arm(3, 64, 8'h30);
        runp[3*9 +: 9] = 9'h030; hold(HOLD);  // valid id, no request
        runp[3*9 +: 9] = 9'h031; hold(HOLD);  // request
        runp[3*9 +: 9] = 9'h000; hold(HOLD);

        req_tag = "R6"; clear_all();
        for (int t = 0; t < NT; t++) arm(t, 7 + t, 8'h10);
        tgt_en[2] = 1'b0; hold(HOLD);
        dist_en = 1'b0; hold(HOLD);

        req_tag = "R1"; clear_all();
        arm(0, 127, 8'hFE); hold(HOLD);       // highest id, mask FF
        prio[127*8 +: 8] = 8'hFF; hold(HOLD); // FF never passes

        req_tag = "R8";
        for (int k = 0; k < 500; k++) begin
            int dens = 1 + $urandom_range(0, 15);
            dist_en = ($urandom_range(0, 15) != 0);
            tgt_en = NT'($urandom);
            if ($urandom_range(0, 3) != 0) tgt_en = '1;
            for (int b = 0; b < NT*NI; b++) begin
                en[b] = ($urandom_range(0, 3) != 0);
                pend[b] = ($urandom_range(0, dens) == 0);
            end
            for (int i = 0; i < NI; i++)
                prio[i*8 +: 8] = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 7) * 32)
                                                             : 8'($urandom);
            for (int t = 0; t < NT; t++) begin
                mask[t*8 +: 8] = ($urandom_range(0, 2) == 0) ? 8'hFF : 8'($urandom);
                runp[t*9 +: 9] = ($urandom_range(0, 2) == 0) ? 9'h100 : 9'($urandom_range(0, 256));
            end
            hold($urandom_range(1, 7));
        end
        hold(HOLD);
        done = 1'b1;
    end

    initial begin
        int wd_fail;
        wd_fail = 0;
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                wd_fail = 1;
            end
        join_any
        if (wd_fail != 0 && !done)
            $display("FAIL R8 watchdog: run not complete after 100000 cycles, expected completion");
        else
            wd_fail = 0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + wd_fail, n_bad + wd_fail);
        $finish;
    end
endmodule